// File: doc/BRIEF.md
# Reloadable Interval Timer with Pin Toggle

This block is a down-counting interval timer. Software reaches it through a small byte-wide register bus. A 16-bit reload value sits in a holding register. Software fills that register one byte at a time. Storing the upper byte at the counter-high offset copies the whole reload value into the counter and starts it. From then on the counter drops by one on every clock. When it passes through zero it raises an interrupt flag. In free-running mode it then refills itself from the holding register. In one-shot mode it flags the first expiry only and then keeps counting from all-ones.

A mode word from the auxiliary control register picks the reload behaviour. It can also hand a port pin to the timer. In pin mode, a start drives the pin low. Each expiry then toggles the pin when free-running, so the pin carries a square wave. In one-shot mode the first expiry drives the pin high, which produces a single low pulse. Three things clear the flag: reading the counter-low byte, writing the reload-high byte, or pulsing a dedicated clear input.

Top module: `ivt_timer`

## Requirements
- R1: After reset the flag is 0, `pin_oe` is 0, `pin_out` is 1, the counter is stopped, and reads of offsets 4, 5, 6 and 7 return 0.
- R2: A write to offset 4 or offset 6 stores the low reload byte. A write to offset 5 or offset 7 stores the high reload byte. Offset 6 reads back the low reload byte and offset 7 the high reload byte. None of these writes except offset 5 changes the counter.
- R3: A write to offset 5 loads the counter with {written byte, low reload byte} on the next clock. The same write clears the flag and starts the counter running.
- R4: While running, the counter drops by exactly one per clock. Offset 4 reads its low byte and offset 5 its high byte, combinationally.
- R5: An expiry is a clock at which the counter is running and holds 0. In free-running mode (mode bit 6 = 1), every expiry sets the flag and reloads the counter from the reload register. The period is therefore reload value + 1 clocks.
- R6: In one-shot mode (mode bit 6 = 0), the counter wraps to all-ones and keeps counting. Only the first expiry after a load sets the flag. Later passes through zero leave the flag unchanged.
- R7: In pin mode (mode bit 7 = 1), `pin_oe` is 1 once a load has occurred since reset. A load drives `pin_out` to 0. In free-running mode each expiry inverts the pin. In one-shot mode the first expiry after a load drives the pin to 1.
- R8: The flag is cleared by a read strobe at offset 4, by a write at offset 7, or by `flag_clr`. An expiry that sets the flag in the same clock takes precedence over any clear.
- R9: Writes to offsets other than 4 to 7 change nothing, and reads of those offsets return 0.
- R10: While mode bit 7 is 0, `pin_oe` is 0 and `pin_out` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the counter steps once per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 4 | Register offset for reads and writes |
| wr_en | input | 1 | Write strobe, one clock per write |
| rd_en | input | 1 | Read strobe; only its clearing side effect is clocked |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Combinational read data for `reg_sel` |
| mode_ctl | input | 8 | Mode word: bit 6 selects free-running, bit 7 selects pin mode |
| flag_clr | input | 1 | Clears the interrupt flag |
| irq_flag | output | 1 | Timeout flag |
| pin_out | output | 1 | Timer-driven pin value |
| pin_oe | output | 1 | Pin output enable |

## Verification
The hardest case to reach from the ports is a one-shot counter passing through zero a second time. That second expiry must leave the flag untouched, but it happens only after the counter has wrapped through the full 16-bit range. The bench starts a short one-shot count and clears the first flag through a counter-low read. It then runs the timer for more than 65,536 clocks, so the wrapped counter really does reach zero again, and checks that the flag and pin stay put. A second stimulus holds the clear input high through several free-running expiries, which shows that an expiry takes precedence over a clear in the same clock.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
   // Decoded view of the mode word
   typedef struct packed {
      logic free_run;
      logic pin_en;
   } ivt_mode_t;
endpackage

// File: rtl/ivt_latch.sv
// Reload holding register, filled one bus byte at a time
module ivt_latch #(
   parameter int unsigned BUS_W = 8,
   parameter int unsigned SEL_W = 4,
   parameter logic [SEL_W-1:0] LO_A = 4,
   parameter logic [SEL_W-1:0] LO_B = 6,
   parameter logic [SEL_W-1:0] HI_A = 5,
   parameter logic [SEL_W-1:0] HI_B = 7
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [SEL_W-1:0]   reg_sel,
   input  logic [BUS_W-1:0]   wr_data,
   output logic [2*BUS_W-1:0] latch_q
);
   localparam int unsigned NLANE = 2;

   for (genvar g = 0; g < NLANE; g++) begin : g_lane
      localparam bit IS_HI = (g == 1);
      logic             sel_hit;
      logic [BUS_W-1:0] byte_q;

      if (IS_HI) begin : g_hi
         assign sel_hit = wr_en && (reg_sel == HI_A || reg_sel == HI_B);
      end else begin : g_lo
         assign sel_hit = wr_en && (reg_sel == LO_A || reg_sel == LO_B);
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       byte_q <= '0;
         else if (sel_hit) byte_q <= wr_data;
      end

      assign latch_q[g*BUS_W +: BUS_W] = byte_q;
   end
endmodule

// File: rtl/ivt_core.sv
// Down counter with reload, one-shot arming and the flag
module ivt_core #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic [CNT_W-1:0] latch,
   input  logic             free_run,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt_q,
   output logic             running_q,
   output logic             armed_q,
   output logic             flag_q,
   output logic             hit
);
   logic expire;

   assign expire = running_q && (cnt_q == '0);
   assign hit    = expire && (free_run || armed_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         running_q <= 1'b0;
         armed_q   <= 1'b0;
         flag_q    <= 1'b0;
      end else if (load) begin
         cnt_q     <= load_val;
         running_q <= 1'b1;
         armed_q   <= 1'b1;
         flag_q    <= 1'b0;
      end else begin
         if (running_q)
            cnt_q <= (expire && free_run) ? latch : cnt_q - 1'b1;
         if (expire && !free_run)
            armed_q <= 1'b0;
         if (hit)
            flag_q <= 1'b1;
         else if (clr)
            flag_q <= 1'b0;
      end
   end
endmodule

// File: rtl/ivt_pin.sv
// Pin driver: square wave or single pulse
module ivt_pin (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   input  logic pin_en,
   input  logic free_run,
   input  logic hit,
   output logic pin_q,
   output logic oe_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_q <= 1'b1;
         oe_q  <= 1'b0;
      end else if (load) begin
         oe_q <= 1'b1;
         if (pin_en) pin_q <= 1'b0;
      end else if (hit && pin_en) begin
         pin_q <= free_run ? ~pin_q : 1'b1;
      end
   end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
   import ivt_pkg::*;
#(
   parameter int unsigned BUS_W      = 8,
   parameter int unsigned SEL_W      = 4,
   parameter int unsigned MODE_W     = 8,
   parameter int unsigned FREE_BIT   = 6,
   parameter int unsigned PIN_BIT    = 7,
   parameter int unsigned SEL_CNT_LO = 4,
   parameter int unsigned SEL_CNT_HI = 5,
   parameter int unsigned SEL_LAT_LO = 6,
   parameter int unsigned SEL_LAT_HI = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SEL_W-1:0]  reg_sel,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [BUS_W-1:0]  wr_data,
   output logic [BUS_W-1:0]  rd_data,
   input  logic [MODE_W-1:0] mode_ctl,
   input  logic              flag_clr,
   output logic              irq_flag,
   output logic              pin_out,
   output logic              pin_oe
);
   localparam int unsigned CNT_W = 2 * BUS_W;
   localparam logic [SEL_W-1:0] A_CLO = SEL_W'(SEL_CNT_LO);
   localparam logic [SEL_W-1:0] A_CHI = SEL_W'(SEL_CNT_HI);
   localparam logic [SEL_W-1:0] A_LLO = SEL_W'(SEL_LAT_LO);
   localparam logic [SEL_W-1:0] A_LHI = SEL_W'(SEL_LAT_HI);

   // Elaboration-time parameter checks
   if (BUS_W < 2) begin : g_bad_bus
      $error("ivt_timer: BUS_W must be at least 2");
   end
   if (FREE_BIT >= MODE_W || PIN_BIT >= MODE_W || FREE_BIT == PIN_BIT) begin : g_bad_mode
      $error("ivt_timer: mode bit positions invalid");
   end
   if (SEL_CNT_LO >= (1 << SEL_W) || SEL_CNT_HI >= (1 << SEL_W) ||
       SEL_LAT_LO >= (1 << SEL_W) || SEL_LAT_HI >= (1 << SEL_W)) begin : g_bad_sel
      $error("ivt_timer: offset exceeds select width");
   end
   if (SEL_CNT_LO == SEL_CNT_HI || SEL_CNT_LO == SEL_LAT_LO || SEL_CNT_LO == SEL_LAT_HI ||
       SEL_CNT_HI == SEL_LAT_LO || SEL_CNT_HI == SEL_LAT_HI || SEL_LAT_LO == SEL_LAT_HI) begin : g_dup_sel
      $error("ivt_timer: offsets must be distinct");
   end

   ivt_mode_t        mode;
   logic [CNT_W-1:0] latch_w;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] load_val_w;
   logic             load_w;
   logic             clr_w;
   logic             running_w;
   logic             armed_w;
   logic             flag_w;
   logic             hit_w;
   logic             pin_w;
   logic             oe_w;

   assign mode.free_run = mode_ctl[FREE_BIT];
   assign mode.pin_en   = mode_ctl[PIN_BIT];

   assign load_w     = wr_en && (reg_sel == A_CHI);
   assign load_val_w = {wr_data, latch_w[BUS_W-1:0]};
   assign clr_w      = flag_clr || (rd_en && reg_sel == A_CLO) ||
                       (wr_en && reg_sel == A_LHI);

   ivt_latch #(
      .BUS_W(BUS_W), .SEL_W(SEL_W),
      .LO_A(A_CLO), .LO_B(A_LLO), .HI_A(A_CHI), .HI_B(A_LHI)
   ) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .reg_sel (reg_sel),
      .wr_data (wr_data),
      .latch_q (latch_w)
   );

   ivt_core #(.CNT_W(CNT_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load_w),
      .load_val  (load_val_w),
      .latch     (latch_w),
      .free_run  (mode.free_run),
      .clr       (clr_w),
      .cnt_q     (cnt_w),
      .running_q (running_w),
      .armed_q   (armed_w),
      .flag_q    (flag_w),
      .hit       (hit_w)
   );

   ivt_pin u_pin (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load_w),
      .pin_en   (mode.pin_en),
      .free_run (mode.free_run),
      .hit      (hit_w),
      .pin_q    (pin_w),
      .oe_q     (oe_w)
   );

   always_comb begin
      if (reg_sel == A_CLO)      rd_data = cnt_w[BUS_W-1:0];
      else if (reg_sel == A_CHI) rd_data = cnt_w[CNT_W-1:BUS_W];
      else if (reg_sel == A_LLO) rd_data = latch_w[BUS_W-1:0];
      else if (reg_sel == A_LHI) rd_data = latch_w[CNT_W-1:BUS_W];
      else                       rd_data = '0;
   end

   assign irq_flag = flag_w;
   assign pin_out  = pin_w;
   assign pin_oe   = oe_w && mode.pin_en;
endmodule

// File: rtl/ivt_timer_chk.sv
module ivt_timer_chk #(
   parameter int unsigned CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             load,
   input logic [CNT_W-1:0] load_val,
   input logic             clr,
   input logic             free_run,
   input logic             pin_en,
   input logic [CNT_W-1:0] cnt,
   input logic [CNT_W-1:0] latch,
   input logic             running,
   input logic             armed,
   input logic             irq_flag,
   input logic             pin_oe,
   input logic             pin_out
);
   // R3
   a_r3_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == $past(load_val) && running && !irq_flag));
   // R4
   a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt != '0 && !load) |=> cnt == $past(cnt) - 1'b1);
   // R5
   a_r5_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt == '0 && free_run && !load) |=> (cnt == $past(latch) && irq_flag));
   // R6
   a_r6_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (running && cnt == '0 && !free_run && !armed && !load && !irq_flag) |=> !irq_flag);
   // R7
   a_r7_oe_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
      pin_oe |-> pin_en);
   // R8
   a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !load && !(running && cnt == '0)) |=> !irq_flag);
   // R10
   a_r10_pin_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_en |=> $stable(pin_out));
endmodule

bind ivt_timer ivt_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .load     (load_w),
   .load_val (load_val_w),
   .clr      (clr_w),
   .free_run (mode.free_run),
   .pin_en   (mode.pin_en),
   .cnt      (cnt_w),
   .latch    (latch_w),
   .running  (running_w),
   .armed    (armed_w),
   .irq_flag (irq_flag),
   .pin_oe   (pin_oe),
   .pin_out  (pin_out)
);

// File: tb/ivt_timer_bench.sv
module ivt_timer_bench;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] reg_sel = 4'd0;
   logic       wr_en = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] rd_data;
   logic [7:0] mode_ctl = 8'd0;
   logic       flag_clr = 1'b0;
   logic       irq_flag;
   logic       pin_out;
   logic       pin_oe;

   int n_tests = 0;
   int n_fail  = 0;
   int cyc     = 0;
   bit done    = 0;

   // behavioural reference state
   int m_cnt = 0, m_lat = 0, m_run = 0, m_arm = 0, m_fl = 0, m_pin = 1, m_oe = 0;

   ivt_timer u_ivt_timer (
      .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
      .wr_data(wr_data), .rd_data(rd_data), .mode_ctl(mode_ctl), .flag_clr(flag_clr),
      .irq_flag(irq_flag), .pin_out(pin_out), .pin_oe(pin_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input bit ok, input string tag, input int act, input int expv);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic int exp_rd(input int sel);
      case (sel)
         4: return m_cnt & 'hFF;
         5: return (m_cnt >> 8) & 'hFF;
         6: return m_lat & 'hFF;
         7: return (m_lat >> 8) & 'hFF;
         default: return 0;
      endcase
   endfunction

   // Reference model, stepped on every rising edge and compared a quarter period later
   always @(posedge clk) begin
      int old_lat, fr, pe, to, hit, clr;
      if (!rst_n) begin
         m_cnt = 0; m_lat = 0; m_run = 0; m_arm = 0; m_fl = 0; m_pin = 1; m_oe = 0;
      end else begin
         old_lat = m_lat;
         fr  = int'(mode_ctl[6]);
         pe  = int'(mode_ctl[7]);
         to  = (m_run != 0 && m_cnt == 0) ? 1 : 0;
         hit = (to != 0 && (fr != 0 || m_arm != 0)) ? 1 : 0;
         clr = (flag_clr || (rd_en && reg_sel == 4) || (wr_en && reg_sel == 7)) ? 1 : 0;
         if (wr_en && (reg_sel == 4 || reg_sel == 6)) m_lat = (m_lat & 'hFF00) | int'(wr_data);
         if (wr_en && (reg_sel == 5 || reg_sel == 7)) m_lat = (m_lat & 'hFF) | (int'(wr_data) << 8);
         if (wr_en && reg_sel == 5) begin
            m_cnt = m_lat; m_run = 1; m_arm = 1; m_fl = 0; m_oe = 1;
            if (pe != 0) m_pin = 0;
         end else begin
            if (m_run != 0) m_cnt = (to != 0 && fr != 0) ? old_lat : ((m_cnt + 'hFFFF) & 'hFFFF);
            if (hit != 0) m_fl = 1;
            else if (clr != 0) m_fl = 0;
            if (hit != 0 && pe != 0) m_pin = (fr != 0) ? (1 - m_pin) : 1;
            if (to != 0 && fr == 0) m_arm = 0;
         end
      end
      #(CLK_PERIOD/4);
      if (rst_n && !done) begin
         chk(int'(irq_flag) == m_fl, "R5 flag vs model", int'(irq_flag), m_fl);
         chk(int'(pin_out) == m_pin, "R7 pin vs model", int'(pin_out), m_pin);
         chk(int'(pin_oe) == ((m_oe != 0 && mode_ctl[7]) ? 1 : 0), "R7 oe vs model",
             int'(pin_oe), (m_oe != 0 && mode_ctl[7]) ? 1 : 0);
         chk(int'(rd_data) == exp_rd(int'(reg_sel)), "R4 read vs model",
             int'(rd_data), exp_rd(int'(reg_sel)));
      end
   end

   task automatic finish_run();
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=%0d expected<=150000", cyc);
         finish_run();
      end
   end

   task automatic wr(input int sel, input int d);
      @(negedge clk);
      wr_en = 1'b1; reg_sel = 4'(sel); wr_data = 8'(d);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic peek(input int sel, input int expv, input string tag);
      @(negedge clk);
      reg_sel = 4'(sel);
      #1;
      chk(int'(rd_data) == expv, tag, int'(rd_data), expv);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      int last_pin, last_edge, highs;
      idle(3);
      // R1: reset state
      chk(irq_flag == 1'b0, "R1 flag", int'(irq_flag), 0);
      chk(pin_oe == 1'b0, "R1 oe", int'(pin_oe), 0);
      chk(pin_out == 1'b1, "R1 pin", int'(pin_out), 1);
      @(negedge clk); rst_n = 1'b1;
      peek(4, 0, "R1 cnt lo"); peek(5, 0, "R1 cnt hi");
      peek(6, 0, "R1 lat lo"); peek(7, 0, "R1 lat hi");

      // R2: byte writes to the reload register
      wr(6, 'h05); wr(7, 'h00);
      peek(6, 'h05, "R2 lat lo"); peek(7, 'h00, "R2 lat hi");
      wr(4, 'h07); peek(6, 'h07, "R2 lat lo via 4");
      peek(4, 'h00, "R2 counter untouched");
      wr(4, 'h05);

      // R3, R5, R7: free-running square wave, reload 5 -> period 6
      mode_ctl = 8'hC0;
      wr(5, 'h00);
      chk(pin_out == 1'b0, "R7 load drives low", int'(pin_out), 0);
      chk(pin_oe == 1'b1, "R7 oe after load", int'(pin_oe), 1);
      peek(4, 'h04, "R3 counter loaded then stepping");
      last_pin = int'(pin_out); last_edge = -1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (int'(pin_out) != last_pin) begin
            if (last_edge >= 0) chk(i - last_edge == 6, "R5 period", i - last_edge, 6);
            last_edge = i; last_pin = int'(pin_out);
         end
      end
      chk(last_edge >= 0, "R5 pin toggled", last_edge, 0);

      // R8: clear held through expiries, expiry wins
      wr(6, 'h02); wr(7, 'h00); wr(5, 'h00);
      @(negedge clk); flag_clr = 1'b1;
      highs = 0;
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         if (irq_flag) highs++;
      end
      chk(highs > 0, "R8 set beats clear", highs, 1);
      flag_clr = 1'b0;

      // R6: one-shot, reload 3
      mode_ctl = 8'h80;
      wr(4, 'h03); wr(5, 'h00);
      idle(5);
      chk(irq_flag == 1'b1, "R6 first expiry flag", int'(irq_flag), 1);
      chk(pin_out == 1'b1, "R7 one-shot pin high", int'(pin_out), 1);
      peek(5, 'hFF, "R6 counter wrapped");
      @(negedge clk); rd_en = 1'b1; reg_sel = 4'd4;
      @(negedge clk); rd_en = 1'b0;
      #1; chk(irq_flag == 1'b0, "R8 read clears", int'(irq_flag), 0);
      idle(65540);
      chk(irq_flag == 1'b0, "R6 no second flag", int'(irq_flag), 0);
      chk(pin_out == 1'b1, "R6 pin stays high", int'(pin_out), 1);

      // R10: pin mode off
      mode_ctl = 8'h40;
      #1; chk(pin_oe == 1'b0, "R10 oe off", int'(pin_oe), 0);
      last_pin = int'(pin_out);
      wr(4, 'h02); wr(5, 'h00);
      idle(20);
      chk(int'(pin_out) == last_pin, "R10 pin held", int'(pin_out), last_pin);

      // R9: unused offsets
      wr(2, 'hAA); wr(11, 'h55);
      peek(2, 0, "R9 read unused 2"); peek(11, 0, "R9 read unused 11");
      peek(6, 'h02, "R9 lat lo intact"); peek(7, 'h00, "R9 lat hi intact");

      // Mixed traffic, longer reload, compared every clock
      mode_ctl = 8'hC0;
      wr(6, 'h23); wr(5, 'h01);
      for (int i = 0; i < 1200; i++) begin
         @(negedge clk);
         flag_clr = (i % 97) == 13;
         rd_en    = (i % 53) == 7;
         reg_sel  = 4'((i / 5) % 16);
         if (i == 600) mode_ctl = 8'h80;
         if (i == 900) mode_ctl = 8'h40;
      end
      flag_clr = 1'b0; rd_en = 1'b0;
      idle(2);
      finish_run();
   end
endmodule